// File: doc/BRIEF.md
# Dual-Channel Serial Control Register Bank

This block is the slave side of a four-wire serial control port for a device with two identical channels. An external master frames each transfer with an active-low chip select. Data on the serial input is taken on rising serial-clock edges, and the bits form 16-bit words. The first byte of each word is a header: its top bit is the direction (1 = read) and its low seven bits are the register address. The second byte is the data byte.

A write updates the addressed register when the sixteenth bit arrives. A read sends the addressed register back on the serial output during the data byte. Several words can follow one another inside a single chip-select window. A word that is cut short by chip select rising is dropped.

The register map holds:
- two fixed identification bytes;
- a soft-reset register whose per-channel bits act once and clear at once;
- a power-down register;
- two control bytes for each channel, which drive the channel control outputs directly.

Each channel's power-down output is the OR of its register bit and an external active-high pin. The asynchronous reset input acts as the power-on reset and restores every default.

The serial pins are sampled by the system clock through synchronizers, and their edges are detected in that domain. All state therefore lives in one clock domain.

Top module: `spi_dual_ctl`

## Requirements
- R1: After `rst_n` is released, both channels show control byte 0 = 0x20 and control byte 1 = 0x14. With both pins low, both power-down outputs are 0. Reads of addresses 0x02 and 0x03 return 0x00.
- R2: While `cs_n` is low, a word is 16 bits taken MSB first on rising `sclk` edges. Bit 7 of the first byte is the direction (0 = write, 1 = read), bits 6:0 are the address, and the second byte is the data. A write updates the register after the 16th rising edge of the word. Addresses 0x04, 0x05, 0x06 and 0x07 hold channel A byte 0, channel A byte 1, channel B byte 0 and channel B byte 1, and read back what was written.
- R3: In a read word, the addressed register's value appears on `sdo` MSB first. Each bit changes after a falling `sclk` edge and is valid at the next rising edge, so the data is sampled at rising edges 9 to 16. `sdo` is 0 while `cs_n` is high.
- R4: Address 0x00 reads 0xB3 and address 0x01 reads 0x23. Writes to these addresses change no register.
- R5: Addresses 0x08 to 0x7F read 0x00. Writes to them change no register.
- R6: At address 0x03, bit 0 is the channel A power-down bit and bit 4 is the channel B power-down bit (1 = down). All other bits read 0, so writing 0xFF reads back 0x11.
- R7: `pd_a` is high when `pd_pin_a` or the channel A register bit is 1, and `pd_b` works the same way for channel B. While a channel is powered down, its control registers keep their contents.
- R8: In a write to address 0x02, bit 0 returns only channel A's two control bytes to their defaults, and bit 4 does the same for channel B only. Both bits may act in the same write. Address 0x02 always reads 0x00, and the power-down register is not touched.
- R9: Consecutive 16-bit words within one `cs_n` low window are each decoded and acted upon, for both writes and reads.
- R10: If `cs_n` rises before the 16th bit of a word, that word writes nothing.
- R11: Asserting `rst_n` at any time restores all control registers and the power-down register to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data to the master |
| pd_pin_a | input | 1 | External power-down request, channel A |
| pd_pin_b | input | 1 | External power-down request, channel B |
| pd_a | output | 1 | Channel A power-down control |
| pd_b | output | 1 | Channel B power-down control |
| ctl_a0 | output | 8 | Channel A control byte 0 |
| ctl_a1 | output | 8 | Channel A control byte 1 |
| ctl_b0 | output | 8 | Channel B control byte 0 |
| ctl_b1 | output | 8 | Channel B control byte 1 |

## Verification
The two channel soft resets can fire in the same clock cycle, because one write to the reset register carrying 0x11 triggers both. The bench provokes this with non-default values in all four control bytes, a power-down register bit set and an external pin held high. It then checks that all four bytes return to their defaults while the power-down register keeps its value. The single-channel resets are exercised separately and are judged by the other channel's bytes staying unchanged.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 2 * DATA_W;
  localparam int NUM_CH  = 2;
  localparam int CH_BIT_STRIDE = 4;

  localparam logic [ADDR_W-1:0] ADR_ID0   = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_ID1   = 7'h01;
  localparam logic [ADDR_W-1:0] ADR_SRST  = 7'h02;
  localparam logic [ADDR_W-1:0] ADR_PDN   = 7'h03;
  localparam logic [ADDR_W-1:0] ADR_CTL_BASE = 7'h04;

  localparam logic [DATA_W-1:0] ID0_VAL  = 8'hB3;
  localparam logic [DATA_W-1:0] ID1_VAL  = 8'h23;
  localparam logic [DATA_W-1:0] CTL0_DEF = 8'h20;
  localparam logic [DATA_W-1:0] CTL1_DEF = 8'h14;

  typedef struct packed {
    logic [DATA_W-1:0] ctl0;
    logic [DATA_W-1:0] ctl1;
  } chan_regs_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cs_act,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic              sclk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FRAME_W-2:0] sh_q, sh_n;
  logic [DATA_W-1:0] hdr_q, hdr_n;
  logic              rd_q, rd_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              sdo_q, sdo_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              rise, fall;

  assign cs_act  = ~cs_n_s;
  assign rise    = cs_act & sclk_s & ~sclk_d;
  assign fall    = cs_act & ~sclk_s & sclk_d;
  assign rd_addr = {sh_q[ADDR_W-2:0], sdi_s};

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    hdr_n = hdr_q;
    rd_n  = rd_q;
    tx_n  = tx_q;
    sdo_n = sdo_q;
    wr_n  = 1'b0;
    wa_n  = wa_q;
    wd_n  = wd_q;
    if (!cs_act) begin
      cnt_n = '0;
      rd_n  = 1'b0;
      sdo_n = 1'b0;
    end else if (rise) begin
      sh_n  = {sh_q[FRAME_W-3:0], sdi_s};
      cnt_n = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
      if (cnt_q == LAST_HDR) begin
        hdr_n = {sh_q[DATA_W-2:0], sdi_s};
        rd_n  = sh_q[DATA_W-2];
        tx_n  = rd_data;
      end
      if (cnt_q == LAST_BIT) begin
        wr_n = ~hdr_q[DATA_W-1];
        wa_n = hdr_q[ADDR_W-1:0];
        wd_n = {sh_q[DATA_W-2:0], sdi_s};
        rd_n = 1'b0;
      end
    end else if (fall) begin
      if (rd_q) begin
        sdo_n = tx_q[DATA_W-1];
        tx_n  = {tx_q[DATA_W-2:0], 1'b0};
      end else begin
        sdo_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      hdr_q  <= '0;
      rd_q   <= 1'b0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
      wr_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      hdr_q  <= hdr_n;
      rd_q   <= rd_n;
      tx_q   <= tx_n;
      sdo_q  <= sdo_n;
      wr_q   <= wr_n;
      wa_q   <= wa_n;
      wd_q   <= wd_n;
    end
  end

  assign wr_en   = wr_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sdo     = sdo_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_ctl_pkg::*;
#(
  parameter int CHANNELS = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output chan_regs_t        regs [CHANNELS],
  output logic [CHANNELS-1:0] pd_reg
);
  logic [DATA_W-1:0] ch_rd  [CHANNELS];
  logic [DATA_W-1:0] pd_img;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    localparam int BITPOS = ch * CH_BIT_STRIDE;
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(ADR_CTL_BASE + 2 * ch);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(ADR_CTL_BASE + 2 * ch + 1);

    chan_regs_t q, n;
    logic pd_q, pd_n;

    always_comb begin
      n    = q;
      pd_n = pd_q;
      if (wr_en) begin
        if (wr_addr == ADR_SRST && wr_data[BITPOS]) begin
          n.ctl0 = CTL0_DEF;
          n.ctl1 = CTL1_DEF;
        end
        if (wr_addr == A0) n.ctl0 = wr_data;
        if (wr_addr == A1) n.ctl1 = wr_data;
        if (wr_addr == ADR_PDN) pd_n = wr_data[BITPOS];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q.ctl0 <= CTL0_DEF;
        q.ctl1 <= CTL1_DEF;
        pd_q   <= 1'b0;
      end else begin
        q    <= n;
        pd_q <= pd_n;
      end
    end

    assign regs[ch]   = q;
    assign pd_reg[ch] = pd_q;
    assign ch_rd[ch]  = (rd_addr == A0) ? q.ctl0 :
                        (rd_addr == A1) ? q.ctl1 : '0;
  end

  always_comb begin
    pd_img = '0;
    for (int c = 0; c < CHANNELS; c++) pd_img[c*CH_BIT_STRIDE] = pd_reg[c];
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < CHANNELS; c++) rd_data = rd_data | ch_rd[c];
    case (rd_addr)
      ADR_ID0: rd_data = ID0_VAL;
      ADR_ID1: rd_data = ID1_VAL;
      ADR_PDN: rd_data = pd_img;
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_dual_ctl.sv
module spi_dual_ctl
  import spi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  input  logic       pd_pin_a,
  input  logic       pd_pin_b,
  output logic       pd_a,
  output logic       pd_b,
  output logic [7:0] ctl_a0,
  output logic [7:0] ctl_a1,
  output logic [7:0] ctl_b0,
  output logic [7:0] ctl_b1
);
  logic [2:0]        pins_s;
  logic              cs_act;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  chan_regs_t        regs [NUM_CH];
  logic [NUM_CH-1:0] pd_reg;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_data(rd_data), .rd_addr(rd_addr), .cs_act(cs_act),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo)
  );

  spi_reg_bank #(.CHANNELS(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs(regs), .pd_reg(pd_reg)
  );

  assign pd_a   = pd_pin_a | pd_reg[0];
  assign pd_b   = pd_pin_b | pd_reg[1];
  assign ctl_a0 = regs[0].ctl0;
  assign ctl_a1 = regs[0].ctl1;
  assign ctl_b0 = regs[1].ctl0;
  assign ctl_b1 = regs[1].ctl1;
endmodule

module spi_dual_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       sdo,
  input logic       wr_en,
  input logic [6:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       pd_pin_a,
  input logic       pd_pin_b,
  input logic       pd_a,
  input logic       pd_b,
  input logic [7:0] ctl_a0,
  input logic [7:0] ctl_a1,
  input logic [7:0] ctl_b0,
  input logic [7:0] ctl_b1
);
  a_r3_sdo_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);

  a_r7_pin_forces_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pin_a |-> pd_a) and (pd_pin_b |-> pd_b));

  a_r6_pd_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'h03 && wr_data[0] && wr_data[4]) |=> (pd_a && pd_b));

  a_r8_chan_a_reset_local: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'h02 && wr_data[0] && !wr_data[4]) |=>
      (ctl_a0 == 8'h20 && ctl_a1 == 8'h14 && $stable(ctl_b0) && $stable(ctl_b1)));

  a_r8_chan_b_reset_local: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 7'h02 && wr_data[4] && !wr_data[0]) |=>
      (ctl_b0 == 8'h20 && ctl_b1 == 8'h14 && $stable(ctl_a0) && $stable(ctl_a1)));

  // R4 and R5: writes to read-only space leave the control bytes alone
  a_r5_ro_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < 7'h02 || wr_addr > 7'h07)) |=>
      ($stable(ctl_a0) && $stable(ctl_a1) && $stable(ctl_b0) && $stable(ctl_b1)));
endmodule

bind spi_dual_ctl spi_dual_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sdo(sdo),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pd_pin_a(pd_pin_a), .pd_pin_b(pd_pin_b), .pd_a(pd_a), .pd_b(pd_b),
  .ctl_a0(ctl_a0), .ctl_a1(ctl_a1), .ctl_b0(ctl_b0), .ctl_b1(ctl_b1)
);

// File: tb/sim_spi_dual_ctl.sv
`timescale 1ns/1ps
module sim_spi_dual_ctl;
  localparam time CLK_HALF = 2ns;
  localparam time SCK_HALF = 64ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic pd_pin_a = 1'b0, pd_pin_b = 1'b0;
  logic sdo, pd_a, pd_b;
  logic [7:0] ctl_a0, ctl_a1, ctl_b0, ctl_b1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  spi_dual_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .pd_pin_a(pd_pin_a), .pd_pin_b(pd_pin_b), .pd_a(pd_a), .pd_b(pd_b),
    .ctl_a0(ctl_a0), .ctl_a1(ctl_a1), .ctl_b0(ctl_b0), .ctl_b1(ctl_b1)
  );

  // {address byte, write data, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    {8'h04, 8'h5A, 8'h5A},   // R2 channel A byte 0
    {8'h05, 8'h27, 8'h27},   // R2 channel A byte 1
    {8'h06, 8'hC3, 8'hC3},   // R2 channel B byte 0
    {8'h07, 8'h01, 8'h01},   // R2 channel B byte 1
    {8'h03, 8'hFF, 8'h11},   // R6 reserved bits read 0
    {8'h00, 8'h00, 8'hB3},   // R4 id byte 0
    {8'h01, 8'hFF, 8'h23},   // R4 id byte 1
    {8'h08, 8'hAA, 8'h00},   // R5 low end of unused space
    {8'h7F, 8'h55, 8'h00},   // R5 top of unused space
    {8'h03, 8'h00, 8'h00}    // R6 clear power-down bits
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // shift n bits of w, MSB first; capture sdo before rising edges 9..16
  task automatic shift_bits(input logic [15:0] w, input int n, output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < n; i++) begin
      sdi = w[15-i];
      #SCK_HALF;
      if (i >= 8) rd[15-i] = sdo;
      sclk = 1'b1;
      #SCK_HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    #SCK_HALF;
  endtask

  task automatic cs_close();
    #SCK_HALF;
    cs_n = 1'b1;
    #(2*SCK_HALF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] junk;
    cs_open();
    shift_bits({a & 8'h7F, d}, 16, junk);
    cs_close();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cs_open();
    shift_bits({a | 8'h80, 8'h00}, 16, d);
    cs_close();
  endtask

  initial begin
    logic [7:0] v, v2;
    #20ns;
    rst_n = 1'b1;
    #40ns;

    // R1 defaults
    check("R1 ctl_a0", ctl_a0, 8'h20);
    check("R1 ctl_a1", ctl_a1, 8'h14);
    check("R1 ctl_b0", ctl_b0, 8'h20);
    check("R1 ctl_b1", ctl_b1, 8'h14);
    check("R1 pd outputs", {6'b0, pd_a, pd_b}, 8'h00);
    rd(8'h03, v); check("R1 pd reg read", v, 8'h00);
    rd(8'h02, v); check("R1 reset reg read", v, 8'h00);
    check("R3 sdo low with cs high", {7'b0, sdo}, 8'h00);

    // table walk: R2 R4 R5 R6
    foreach (VEC[i]) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      check($sformatf("R2/R3 vector %0d addr 0x%02h", i, VEC[i][23:16]), v, VEC[i][7:0]);
    end
    check("R2 port ctl_a0", ctl_a0, 8'h5A);
    check("R2 port ctl_b1", ctl_b1, 8'h01);
    check("R5 ctl_a1 untouched", ctl_a1, 8'h27);
    check("R3 sdo low after read", {7'b0, sdo}, 8'h00);

    // R7 pin or register bit
    pd_pin_a = 1'b1; #40ns;
    check("R7 pin a forces pd_a", {6'b0, pd_a, pd_b}, 8'h02);
    rd(8'h04, v); check("R7 reg kept while down", v, 8'h5A);
    pd_pin_a = 1'b0; #40ns;
    check("R7 pin a released", {6'b0, pd_a, pd_b}, 8'h00);
    wr(8'h03, 8'h10);
    check("R7 reg bit b", {6'b0, pd_a, pd_b}, 8'h01);
    pd_pin_b = 1'b1; wr(8'h03, 8'h00);
    check("R7 pin b alone", {6'b0, pd_a, pd_b}, 8'h01);
    pd_pin_b = 1'b0; #40ns;
    check("R7 all up", {6'b0, pd_a, pd_b}, 8'h00);

    // R8 per-channel soft reset
    wr(8'h02, 8'h01);
    check("R8 reset A ctl_a0", ctl_a0, 8'h20);
    check("R8 reset A ctl_a1", ctl_a1, 8'h14);
    check("R8 reset A keeps b0", ctl_b0, 8'hC3);
    check("R8 reset A keeps b1", ctl_b1, 8'h01);
    rd(8'h02, v); check("R8 reset reg self-clears", v, 8'h00);
    wr(8'h04, 8'h99);
    wr(8'h02, 8'h10);
    check("R8 reset B ctl_b0", ctl_b0, 8'h20);
    check("R8 reset B ctl_b1", ctl_b1, 8'h14);
    check("R8 reset B keeps a0", ctl_a0, 8'h99);
    // both resets in one write, with pd bit and pin set
    wr(8'h05, 8'h3C); wr(8'h06, 8'h77); wr(8'h07, 8'hE1);
    wr(8'h03, 8'h01); pd_pin_b = 1'b1;
    wr(8'h02, 8'h11);
    check("R8 both a0", ctl_a0, 8'h20);
    check("R8 both a1", ctl_a1, 8'h14);
    check("R8 both b0", ctl_b0, 8'h20);
    check("R8 both b1", ctl_b1, 8'h14);
    rd(8'h03, v); check("R8 pd reg untouched", v, 8'h01);
    pd_pin_b = 1'b0; wr(8'h03, 8'h00);

    // R9 streaming writes then streaming reads
    cs_open();
    shift_bits({8'h04, 8'hAB}, 16, v);
    shift_bits({8'h06, 8'hCD}, 16, v);
    cs_close();
    check("R9 stream write A0", ctl_a0, 8'hAB);
    check("R9 stream write B0", ctl_b0, 8'hCD);
    cs_open();
    shift_bits({8'h84, 8'h00}, 16, v);
    shift_bits({8'h86, 8'h00}, 16, v2);
    cs_close();
    check("R9 stream read 1", v, 8'hAB);
    check("R9 stream read 2", v2, 8'hCD);

    // R10 partial trailing word
    cs_open();
    shift_bits({8'h05, 8'h77}, 16, v);
    shift_bits({8'h07, 8'h99}, 12, v);
    cs_close();
    check("R10 full word lands", ctl_a1, 8'h77);
    check("R10 partial word dropped", ctl_b1, 8'h14);
    cs_open();
    shift_bits({8'h04, 8'h00}, 8, v);
    cs_close();
    check("R10 header only dropped", ctl_a0, 8'hAB);

    // R11 reset mid-run
    wr(8'h03, 8'h11);
    check("R11 pd set before reset", {6'b0, pd_a, pd_b}, 8'h03);
    @(negedge clk); rst_n = 1'b0; #20ns;
    check("R11 ctl_a0", ctl_a0, 8'h20);
    check("R11 ctl_a1", ctl_a1, 8'h14);
    check("R11 ctl_b0", ctl_b0, 8'h20);
    check("R11 pd cleared", {6'b0, pd_a, pd_b}, 8'h00);
    @(negedge clk); rst_n = 1'b1; #40ns;
    rd(8'h03, v); check("R11 pd reg read", v, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule